// File: doc/BRIEF.md
# Escaped byte-stream packet parser

This block sits behind a serial receiver and turns its physical-layer byte stream back into plain packet bytes. The stream carries framing markers and escape prefixes. The parser throws away idle filler and any noise that comes before a start marker. It strips the escape prefixes, checks the channel field and hands each recovered byte downstream on a valid/ready interface. The first byte of a packet carries a start flag and the last byte carries an end flag. When the stream breaks the framing rules, the parser raises a one-cycle error pulse, drops the packet in progress and hunts for the next start marker.

Framing: 0x7A opens a packet. 0x7B means that the next data byte is the last one. 0x7C means that the next byte is a channel number. 0x7D and 0x4D are escape prefixes: the data byte after a prefix is XORed with 0x20. 0x4A is idle filler. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. The control is a state machine with six states:
- `ST_HUNT`: waits for a start marker and drops everything else. A start marker moves it to `ST_BODY`.
- `ST_BODY`: emits data bytes. 0x7B moves it to `ST_TAIL`, 0x7C to `ST_CHAN`, and an escape prefix to `ST_BODY_ESC`.
- `ST_CHAN`: a matching channel byte returns it to `ST_BODY`. Any other byte is an error and returns it to `ST_HUNT`.
- `ST_BODY_ESC`: a data byte is emitted unescaped and the machine returns to `ST_BODY`. A marker or prefix is an error.
- `ST_TAIL`: a data byte is emitted with the end flag and the machine goes to `ST_HUNT`. An escape prefix moves it to `ST_TAIL_ESC`. 0x7B or 0x7C is an error.
- `ST_TAIL_ESC`: a data byte is emitted unescaped with the end flag and the machine goes to `ST_HUNT`. A marker or prefix is an error.

A start marker seen in any state other than `ST_CHAN` restarts the packet in `ST_BODY`. Idle bytes never change the state.

Top module: `pkt_unstuff`

## Requirements
- R1: After reset, `out_valid` and `err_pulse` are 0, `in_ready` is 1, and the parser is hunting for a start marker.
- R2: While hunting, every byte other than 0x7A is dropped without output and without error.
- R3: Byte 0x4A is dropped in every state. It produces no output and no error and leaves the parse state unchanged.
- R4: A 0x7A arriving in any state except the channel-wait state abandons the current packet and starts a new one.
- R5: The first non-idle byte after 0x7C must equal `CHANNEL_ID` (default 0x00). Any other value, including 0x7A, raises an error.
- R6: A data byte that follows 0x7D or 0x4D is output as that byte XOR 0x20.
- R7: 0x7B, 0x7C, 0x7D or 0x4D arriving directly after an escape prefix raises an error.
- R8: 0x7B or 0x7C arriving after 0x7B has already been seen in the packet raises an error. An escape prefix at that point is legal.
- R9: The first data byte after 0x7B is output with `out_eop`=1 and completes the packet. The parser then hunts again.
- R10: The first data byte output after a 0x7A carries `out_sop`=1. Every other output byte carries `out_sop`=0.
- R11: An error is reported as a one-cycle pulse on `err_pulse`, and the parser then hunts for a new start marker.
- R12: While `out_valid`=1 and `out_ready`=0, the output byte and its flags hold steady and `in_ready` is 0.
- R13: A data byte accepted on a clock edge appears on the output after that edge. An error pulse also appears after the edge on which the offending byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input byte is present |
| in_byte | input | 8 | Physical-layer byte |
| in_ready | output | 1 | The parser can take a byte this cycle |
| out_ready | input | 1 | Downstream takes the output byte |
| out_valid | output | 1 | The output byte is valid |
| out_byte | output | 8 | Recovered packet byte |
| out_sop | output | 1 | The byte is the first of its packet |
| out_eop | output | 1 | The byte is the last of its packet |
| err_pulse | output | 1 | One-cycle protocol-error strobe |

## Verification
Every result, whether a recovered byte with its flags or an error pulse, is registered once. It is due in the cycle that follows the clock edge on which its input byte was accepted. The bench drives each byte at a falling edge while `out_ready` is high. At the next falling edge it compares `out_valid`, the byte, both flags and `err_pulse` against a reference model in the bench. Because the output is not held, a stale value would be caught. The backpressure case holds `out_ready` low for several cycles and checks at each falling edge that the output and `in_ready` do not change. It then checks that the waiting byte appears one cycle after `out_ready` rises.

// File: rtl/pkt_unstuff_pkg.sv
package pkt_unstuff_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] K_SOP  = 8'h7A;
    localparam logic [BYTE_W-1:0] K_EOP  = 8'h7B;
    localparam logic [BYTE_W-1:0] K_CHAN = 8'h7C;
    localparam logic [BYTE_W-1:0] K_ESC  = 8'h7D;
    localparam logic [BYTE_W-1:0] K_IDLE = 8'h4A;
    localparam logic [BYTE_W-1:0] K_PESC = 8'h4D;
    localparam logic [BYTE_W-1:0] K_FLIP = 8'h20;

    typedef enum logic [2:0] {
        SYM_DATA,
        SYM_IDLE,
        SYM_SOP,
        SYM_EOP,
        SYM_CHAN,
        SYM_ESC
    } sym_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CHAN,
        ST_BODY,
        ST_BODY_ESC,
        ST_TAIL,
        ST_TAIL_ESC
    } state_e;
endpackage

// File: rtl/pkt_sym_decode.sv
module pkt_sym_decode
    import pkt_unstuff_pkg::*;
(
    input  logic [BYTE_W-1:0] code_i,
    output sym_e              sym_o
);
    always_comb begin
        if (code_i == K_IDLE)
            sym_o = SYM_IDLE;
        else if (code_i == K_SOP)
            sym_o = SYM_SOP;
        else if (code_i == K_EOP)
            sym_o = SYM_EOP;
        else if (code_i == K_CHAN)
            sym_o = SYM_CHAN;
        else if (code_i == K_ESC || code_i == K_PESC)
            sym_o = SYM_ESC;
        else
            sym_o = SYM_DATA;
    end
endmodule

// File: rtl/pkt_out_stage.sv
module pkt_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         sop_i,
    input  logic         eop_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         sop_o,
    output logic         eop_o,
    output logic         free_o
);
    assign free_o = !valid_o || ready_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            sop_o   <= 1'b0;
            eop_o   <= 1'b0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            data_o  <= data_i;
            sop_o   <= sop_i;
            eop_o   <= eop_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // R12: a stalled output keeps its byte and flags
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(sop_o) && $stable(eop_o)));
endmodule

// File: rtl/pkt_unstuff.sv
module pkt_unstuff
    import pkt_unstuff_pkg::*;
#(
    parameter logic [7:0] CHANNEL_ID = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_sop,
    output logic       out_eop,
    output logic       err_pulse
);
    state_e state, nxt;
    sym_e   sym;
    logic   acc, emit, flip, last, bad, restart, first_q;
    logic [BYTE_W-1:0] emit_byte;

    pkt_sym_decode u_dec (
        .code_i (in_byte),
        .sym_o  (sym)
    );

    assign acc = in_valid && in_ready;

    always_comb begin
        nxt     = state;
        emit    = 1'b0;
        flip    = 1'b0;
        last    = 1'b0;
        bad     = 1'b0;
        restart = 1'b0;
        if (acc && sym != SYM_IDLE) begin
            unique case (state)
                ST_HUNT: begin
                    if (sym == SYM_SOP) restart = 1'b1;
                end
                ST_CHAN: begin
                    if (in_byte == CHANNEL_ID) nxt = ST_BODY;
                    else bad = 1'b1;
                end
                ST_BODY: begin
                    case (sym)
                        SYM_SOP:  restart = 1'b1;
                        SYM_EOP:  nxt = ST_TAIL;
                        SYM_CHAN: nxt = ST_CHAN;
                        SYM_ESC:  nxt = ST_BODY_ESC;
                        default:  emit = 1'b1;
                    endcase
                end
                ST_BODY_ESC: begin
                    case (sym)
                        SYM_SOP:  restart = 1'b1;
                        SYM_DATA: begin emit = 1'b1; flip = 1'b1; nxt = ST_BODY; end
                        default:  bad = 1'b1;
                    endcase
                end
                ST_TAIL: begin
                    case (sym)
                        SYM_SOP:  restart = 1'b1;
                        SYM_ESC:  nxt = ST_TAIL_ESC;
                        SYM_DATA: begin emit = 1'b1; last = 1'b1; nxt = ST_HUNT; end
                        default:  bad = 1'b1;
                    endcase
                end
                ST_TAIL_ESC: begin
                    case (sym)
                        SYM_SOP:  restart = 1'b1;
                        SYM_DATA: begin emit = 1'b1; flip = 1'b1; last = 1'b1; nxt = ST_HUNT; end
                        default:  bad = 1'b1;
                    endcase
                end
                default: bad = 1'b1;
            endcase
            if (restart) nxt = ST_BODY;
            if (bad)     nxt = ST_HUNT;
        end
    end

    assign emit_byte = flip ? (in_byte ^ K_FLIP) : in_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= bad;
            if (restart)   first_q <= 1'b1;
            else if (emit) first_q <= 1'b0;
        end
    end

    pkt_out_stage #(.W(BYTE_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (emit),
        .data_i  (emit_byte),
        .sop_i   (first_q),
        .eop_i   (last),
        .ready_i (out_ready),
        .valid_o (out_valid),
        .data_o  (out_byte),
        .sop_o   (out_sop),
        .eop_o   (out_eop),
        .free_o  (in_ready)
    );

    // R3: idle filler neither errors nor moves the machine
    a_r3_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_byte == K_IDLE) |=> (!err_pulse && state == $past(state)));

    // R2: noise while hunting is dropped
    a_r2_hunt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == ST_HUNT && in_byte != K_SOP) |=> (state == ST_HUNT && !err_pulse));

    // R5: a wrong channel number is flagged
    a_r5_chan_err: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == ST_CHAN && in_byte != K_IDLE && in_byte != CHANNEL_ID) |=> err_pulse);

    // R6: escaped data comes out with bit 5 flipped
    a_r6_unescape: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (state == ST_BODY_ESC || state == ST_TAIL_ESC) && sym == SYM_DATA)
        |=> (out_valid && out_byte == ($past(in_byte) ^ K_FLIP)));

    // R9: the byte after the end marker closes the packet
    a_r9_close: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == ST_TAIL && sym == SYM_DATA) |=> (out_valid && out_eop && state == ST_HUNT));

    // R11: an error lasts one cycle and leaves the parser hunting
    a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (state == ST_HUNT));
    a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
endmodule

// File: tb/test_pkt_unstuff.sv
module test_pkt_unstuff;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       in_ready;
    logic       out_ready;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_sop;
    logic       out_eop;
    logic       err_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state: 0 hunt, 1 chan, 2 body, 3 body-esc, 4 tail, 5 tail-esc
    int m_st    = 0;
    bit m_first = 1'b0;

    always #5 clk = ~clk;

    pkt_unstuff i_pkt_unstuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .err_pulse (err_pulse)
    );

    function automatic bit is_mark(input logic [7:0] b);
        return (b == 8'h7B || b == 8'h7C || b == 8'h7D || b == 8'h4D);
    endfunction

    task automatic model(input logic [7:0] b, output bit ev, output logic [7:0] ed,
                         output bit es, output bit ee, output bit er);
        ev = 0; ed = 8'h00; es = 0; ee = 0; er = 0;
        if (b == 8'h4A) return;
        if (m_st == 1) begin
            if (b == 8'h00) m_st = 2;
            else begin er = 1; m_st = 0; end
            return;
        end
        if (b == 8'h7A) begin m_st = 2; m_first = 1; return; end
        case (m_st)
            2: begin
                if (b == 8'h7B) m_st = 4;
                else if (b == 8'h7C) m_st = 1;
                else if (b == 8'h7D || b == 8'h4D) m_st = 3;
                else begin ev = 1; ed = b; end
            end
            3, 5: begin
                if (is_mark(b)) begin er = 1; m_st = 0; end
                else begin ev = 1; ed = b ^ 8'h20; ee = (m_st == 5); m_st = (m_st == 5) ? 0 : 2; end
            end
            4: begin
                if (b == 8'h7B || b == 8'h7C) begin er = 1; m_st = 0; end
                else if (b == 8'h7D || b == 8'h4D) m_st = 5;
                else begin ev = 1; ed = b; ee = 1; m_st = 0; end
            end
            default: ;
        endcase
        if (ev) begin es = m_first; m_first = 0; end
    endtask

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        bit ev, es, ee, er;
        logic [7:0] ed;
        bit ok;
        model(b, ev, ed, es, ee, er);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        ok = (out_valid == ev) && (err_pulse == er) &&
             (!ev || (out_byte == ed && out_sop == es && out_eop == ee));
        check(ok, tag,
              $sformatf("v=%0b d=%02h s=%0b e=%0b err=%0b (in %02h)", out_valid, out_byte, out_sop, out_eop, err_pulse, b),
              $sformatf("v=%0b d=%02h s=%0b e=%0b err=%0b", ev, ed, es, ee, er));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b1;
        m_st = 0; m_first = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !err_pulse && in_ready, "R1",
              $sformatf("v=%0b err=%0b rdy=%0b", out_valid, err_pulse, in_ready), "v=0 err=0 rdy=1");
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R2: noise before any start marker
        send(8'h11, "R2"); send(8'h7B, "R2"); send(8'h7C, "R2"); send(8'h4A, "R2");
        // R10 R5 R3 R9: clean packet with channel field and idles
        send(8'h7A, "R10"); send(8'h7C, "R5"); send(8'h4A, "R3"); send(8'h00, "R5");
        send(8'h41, "R10"); send(8'h4A, "R3"); send(8'h42, "R13");
        send(8'h7B, "R9"); send(8'h4A, "R3"); send(8'h43, "R9");
        send(8'h55, "R9");
        // R6: both escape prefixes, also after the end marker
        send(8'h7A, "R6"); send(8'h7D, "R6"); send(8'h5A, "R6");
        send(8'h4D, "R6"); send(8'h4A, "R3"); send(8'h6A, "R6");
        send(8'h7B, "R6"); send(8'h7D, "R8"); send(8'h5D, "R6");
        // R4: restart in mid packet and while escaped
        send(8'h7A, "R4"); send(8'h01, "R4"); send(8'h02, "R4");
        send(8'h7A, "R4"); send(8'h03, "R4"); send(8'h7D, "R4");
        send(8'h7A, "R4"); send(8'h7B, "R4"); send(8'h04, "R4");
        // R5: bad channel, and a start marker in the channel slot
        send(8'h7A, "R5"); send(8'h7C, "R5"); send(8'h05, "R5"); send(8'h66, "R11");
        send(8'h7A, "R5"); send(8'h7C, "R5"); send(8'h7A, "R5"); send(8'h67, "R11");
        // R7: markers right after an escape prefix
        send(8'h7A, "R7"); send(8'h7D, "R7"); send(8'h7B, "R7");
        send(8'h7A, "R7"); send(8'h4D, "R7"); send(8'h7C, "R7");
        send(8'h7A, "R7"); send(8'h7D, "R7"); send(8'h4D, "R7");
        // R8: second end marker, channel marker after end marker
        send(8'h7A, "R8"); send(8'h01, "R8"); send(8'h7B, "R8"); send(8'h7B, "R8");
        send(8'h7A, "R8"); send(8'h7B, "R8"); send(8'h7C, "R8"); send(8'h09, "R11");

        // R12: backpressure holds the byte and stops input
        out_ready = 1'b0;
        send(8'h7A, "R12"); send(8'h7C, "R12"); send(8'h00, "R12"); send(8'h11, "R12");
        in_valid = 1'b1; in_byte = 8'h22;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid && out_byte == 8'h11 && out_sop && !in_ready, "R12",
                  $sformatf("v=%0b d=%02h s=%0b rdy=%0b", out_valid, out_byte, out_sop, in_ready),
                  "v=1 d=11 s=1 rdy=0");
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_byte == 8'h22 && !out_sop && !out_eop, "R12",
              $sformatf("v=%0b d=%02h s=%0b", out_valid, out_byte, out_sop), "v=1 d=22 s=0");
        @(negedge clk);
        check(!out_valid, "R13", $sformatf("v=%0b", out_valid), "v=0");

        // random phase, weighted toward control bytes
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] b;
            case ($urandom % 16)
                0, 1: b = 8'h7A;
                2:    b = 8'h7B;
                3:    b = 8'h7C;
                4:    b = 8'h7D;
                5:    b = 8'h4D;
                6:    b = 8'h4A;
                7:    b = 8'h00;
                default: b = 8'($urandom);
            endcase
            send(b, "R13");
        end
        report();
    end
endmodule